// File: doc/BRIEF.md
# Radix-4 Booth Carry-Save Multiplier

This block multiplies two signed two's-complement operands in a single combinational pass. It is parameterised on the operand width, which defaults to 8 bits and gives a 16-bit product. The multiplier operand is recoded into signed radix-4 digits. Each digit in {-2, -1, 0, +1, +2} scales a shifted copy of the multiplicand, so only half as many partial products are formed as there are multiplier bits.

The partial products go into a chain of 3:2 carry-save adders. A separate correction word holds the +1 terms that complete each two's-complement negation. The chain keeps the running total in redundant sum/carry form. One carry-propagate adder at the end resolves it into the product. The block has no clock or storage, and a parent wraps it in whatever register stages its timing needs.

Top module: `booth_mult`

## Requirements
- R1: For every pair of signed 8-bit operands, `product` equals the signed product `mcand * mplier` as a 16-bit two's-complement value.
- R2: Digit i is read from multiplier bits (2i+1, 2i, 2i-1), with bit -1 taken as 0. The triplets map as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. Operands chosen to exercise each triplet must yield correct products.
- R3: For each digit, the single-multiple and double-multiple select lines are never active together.
- R4: The negate line of a digit is active only when one of its select lines is active, so no negative zero is ever injected.
- R5: When either operand is zero, `product` is zero.
- R6: When both operands are nonzero, `product[15]` equals the XOR of the operand sign bits.
- R7: The extreme cases give exact results: -128 x -128 = 0x4000, -128 x 127 = 0xC080, 127 x 127 = 0x3F01, and -128 x 1 = 0xFF80.
- R8: A multiplier of +1 returns the multiplicand sign-extended to 16 bits, and a multiplier of -1 returns its 16-bit negation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 8 | Signed multiplicand |
| mplier | input | 8 | Signed multiplier, recoded into radix-4 digits |
| product | output | 16 | Signed product |

## Verification
A mis-recoded digit, a dropped negation increment or a misaligned carry word changes `product` in the same evaluation as the operands that trigger it. No state hides such a fault, so comparing every operand pair against an integer multiply exposes it on the first vector that uses the faulty digit or column. Faults confined to particular triplets or sign combinations are also targeted by the directed extremes and by the +1/-1 multiplier cases. The checker additionally watches the per-digit control lines, whose conflicts might otherwise cancel out in the sum.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic one;   // select the multiplicand
    logic two;   // select twice the multiplicand
    logic neg;   // subtract the selected multiple
  } booth_ctl_t;

  // Recode one overlapping triplet {hi, mid, lo} into select lines.
  function automatic booth_ctl_t recode(input logic [2:0] trip);
    booth_ctl_t c;
    c.one = trip[1] ^ trip[0];
    c.two = (trip == 3'b011) || (trip == 3'b100);
    c.neg = trip[2] & ~(trip[1] & trip[0]);
    return c;
  endfunction

endpackage

// File: rtl/booth_encoder.sv
module booth_encoder
  import booth_pkg::*;
#(
  parameter int W = 8,
  localparam int NPP = W / 2
) (
  input  logic [W-1:0]   mplier,
  output logic [NPP-1:0] sel_one,
  output logic [NPP-1:0] sel_two,
  output logic [NPP-1:0] sel_neg
);

  logic [W:0] ext;
  assign ext = {mplier, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_digit
    booth_ctl_t ctl;
    assign ctl        = recode(ext[2*i+2 -: 3]);
    assign sel_one[i] = ctl.one;
    assign sel_two[i] = ctl.two;
    assign sel_neg[i] = ctl.neg;
  end

endmodule

// File: rtl/booth_selector.sv
module booth_selector #(
  parameter int W = 8,
  localparam int NPP = W / 2,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]   mcand,
  input  logic [NPP-1:0] sel_one,
  input  logic [NPP-1:0] sel_two,
  input  logic [NPP-1:0] sel_neg,
  output logic [PW-1:0]  pp [NPP+1],
  output logic [PW-1:0]  corr
);

  logic [PW-1:0] m1;
  logic [PW-1:0] m2;
  assign m1 = {{W{mcand[W-1]}}, mcand};
  assign m2 = {m1[PW-2:0], 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [PW-1:0] mult;
    always_comb begin
      mult = '0;
      if (sel_one[i]) mult = m1;
      else if (sel_two[i]) mult = m2;
    end
    assign pp[i] = (mult ^ {PW{sel_neg[i]}}) << (2 * i);
  end

  // Increment words completing each inverted multiple.
  always_comb begin
    corr = '0;
    for (int i = 0; i < NPP; i++) corr[2*i] = sel_neg[i];
  end
  assign pp[NPP] = corr;

endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int PW = 16,
  parameter int NOPS = 5,
  localparam int NST = NOPS - 2
) (
  input  logic [PW-1:0] ops [NOPS],
  output logic [PW-1:0] sum_w,
  output logic [PW-1:0] cry_w
);

  logic [PW-1:0] s [NST];
  logic [PW-1:0] c [NST];

  for (genvar j = 0; j < NST; j++) begin : g_stage
    logic [PW-1:0] x, y, z, maj;
    if (j == 0) begin : g_first
      assign x = ops[0];
      assign y = ops[1];
    end else begin : g_next
      assign x = s[j-1];
      assign y = c[j-1];
    end
    assign z    = ops[j+2];
    assign s[j] = x ^ y ^ z;
    assign maj  = (x & y) | (x & z) | (y & z);
    assign c[j] = {maj[PW-2:0], 1'b0};
  end

  assign sum_w = s[NST-1];
  assign cry_w = c[NST-1];

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int W = 8,
  localparam int NPP = W / 2,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output logic [PW-1:0] product
);

  logic [NPP-1:0] sel_one, sel_two, sel_neg;
  logic [PW-1:0]  pp [NPP+1];
  logic [PW-1:0]  corr;
  logic [PW-1:0]  sum_w, cry_w;

  booth_encoder #(.W(W)) u_enc (
    .mplier (mplier),
    .sel_one(sel_one),
    .sel_two(sel_two),
    .sel_neg(sel_neg)
  );

  booth_selector #(.W(W)) u_sel (
    .mcand  (mcand),
    .sel_one(sel_one),
    .sel_two(sel_two),
    .sel_neg(sel_neg),
    .pp     (pp),
    .corr   (corr)
  );

  csa_chain #(.PW(PW), .NOPS(NPP + 1)) u_csa (
    .ops  (pp),
    .sum_w(sum_w),
    .cry_w(cry_w)
  );

  // Single carry-propagate stage.
  assign product = sum_w + cry_w;

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int W = 8,
  localparam int NPP = W / 2,
  localparam int PW = 2 * W
) (
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic [PW-1:0]  product,
  input logic [NPP-1:0] sel_one,
  input logic [NPP-1:0] sel_two,
  input logic [NPP-1:0] sel_neg
);

  always_comb begin
    if (!$isunknown({mcand, mplier, product, sel_one, sel_two, sel_neg})) begin
      for (int i = 0; i < NPP; i++) begin
        AST_SEL_EXCLUSIVE: assert (!(sel_one[i] && sel_two[i])) else $error("select lines clash"); // R3
        AST_NO_NEG_ZERO: assert (!sel_neg[i] || sel_one[i] || sel_two[i]) else $error("negate without multiple"); // R4
      end
      AST_ZERO_OPERAND: assert (!(mcand == '0 || mplier == '0) || product == '0) else $error("zero operand"); // R5
      AST_SIGN_BIT: assert (mcand == '0 || mplier == '0 || product[PW-1] == (mcand[W-1] ^ mplier[W-1])) else $error("sign"); // R6
      AST_UNIT_MPLIER: assert (mplier != W'(1) || product == {{W{mcand[W-1]}}, mcand}) else $error("unit multiplier"); // R8
    end
  end

endmodule

bind booth_mult booth_mult_chk #(.W(W)) u_chk (
  .mcand  (mcand),
  .mplier (mplier),
  .product(product),
  .sel_one(sel_one),
  .sel_two(sel_two),
  .sel_neg(sel_neg)
);

// File: tb/booth_mult_bench.sv
module booth_mult_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  mcand, mplier;
  logic [15:0] product;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  booth_mult u_booth_mult (.mcand(mcand), .mplier(mplier), .product(product));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int pa, pb;
    pa = int'($signed(a));
    pb = int'($signed(b));
    return 16'(pa * pb);
  endfunction

  task automatic check(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] expv);
    @(posedge clk);
    mcand  = a;
    mplier = b;
    @(negedge clk);
    checks++;
    if (product !== expv) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", tag,
               $signed(a), $signed(b), product, expv);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (product !== 16'h0000) begin
      errors++;
      $display("FAIL R5 reset-state actual=%h expected=0000", product);
    end
    // R2: each triplet pattern in the low digit, then in an upper digit
    check("R2", 8'd37, 8'b0000_0001, ref_mul(8'd37, 8'b0000_0001));
    check("R2", 8'd37, 8'b0000_0010, ref_mul(8'd37, 8'b0000_0010));
    check("R2", 8'd37, 8'b0000_0011, ref_mul(8'd37, 8'b0000_0011));
    check("R2", 8'hC5, 8'b0100_1000, ref_mul(8'hC5, 8'b0100_1000));
    check("R2", 8'hC5, 8'b1010_0110, ref_mul(8'hC5, 8'b1010_0110));
    check("R2", 8'hC5, 8'b1101_1100, ref_mul(8'hC5, 8'b1101_1100));
    // R7 extremes
    check("R7", 8'h80, 8'h80, 16'h4000);
    check("R7", 8'h80, 8'h7F, 16'hC080);
    check("R7", 8'h7F, 8'h7F, 16'h3F01);
    check("R7", 8'h80, 8'h01, 16'hFF80);
    // R8 unit multipliers
    check("R8", 8'h9C, 8'h01, 16'hFF9C);
    check("R8", 8'h9C, 8'hFF, 16'h0064);
    check("R8", 8'h7F, 8'hFF, 16'hFF81);
    // R5 zero operands
    check("R5", 8'h00, 8'h80, 16'h0000);
    check("R5", 8'hA7, 8'h00, 16'h0000);
    // R1, R3, R4, R6: exhaustive sweep
    for (int v = 0; v < 65536; v++) begin
      logic [7:0] a, b;
      a = v[15:8];
      b = v[7:0];
      check("R1", a, b, ref_mul(a, b));
      if (a != 0 && b != 0) begin
        checks++;
        if (product[15] !== (a[7] ^ b[7])) begin
          errors++;
          $display("FAIL R6 sign actual=%b expected=%b", product[15], a[7] ^ b[7]);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule